// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Refresh

This block sits between a simple synchronous requester and an asynchronous DRAM that has a multiplexed address bus. It cuts each requester address into an upper row half and a lower column half. It drives the halves onto the shared address bus in two steps, row first and then column. It times the active-low row and column strobes from clock counts set by parameters. Read data is registered at the end of the column window, and a one-cycle ready pulse ends every request.

The controller keeps a row open after an access. Later requests to the same row skip row activation and go straight to a new column cycle. When a request falls in a different row, the open row is closed first: the row strobe is released only after its minimum low time, and it then stays high for the precharge time. A free-running timer, whose period is derived from the clock rate, raises a refresh request often enough to meet the refresh budget. While the controller is idle, a waiting refresh is run ahead of any request. Refresh uses column-before-row ordering, and afterwards no row counts as open.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is held, both strobes are high (inactive), the read/write select is high, the data output enable is low and ready is low.
- R2: Address bits [2*ADDR_W-1:ADDR_W] are on the DRAM address bus when the row strobe falls for an access, and bits [ADDR_W-1:0] are on it when the column strobe falls with the row strobe low.
- R3: The column strobe of an access falls no earlier than T_RCD clocks after the row strobe fell.
- R4: For an access, the column strobe stays low for exactly T_CAS clocks.
- R5: For a write, the select is low (0 means write, 1 means read), the data output enable is high and the data output equals the request's write data the whole time the column strobe is low. For a read, the output enable stays low.
- R6: On a read, rdata_o holds the word on the DRAM data input at the end of the column window. It is updated only in the cycle in which ready is high.
- R7: A request to the same row as the open row causes no new row strobe fall; the row strobe stays low between the two accesses.
- R8: A row strobe low period lasts at least T_RAS clocks, and a row strobe high period before any fall lasts at least T_RP clocks.
- R9: A refresh request is raised every (CLK_KHZ*REF_WIN_MS)/REF_ROWS clocks and is carried out by lowering the column strobe at least one clock before the row strobe.
- R10: A pending refresh is served before a waiting request, and the first access after any refresh activates its row again.
- R11: ready_o is high for exactly one clock per request and only while a request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, held until ready |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2*ADDR_W | Word address, row half in the upper bits |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Captured read data |
| dram_addr_o | output | ADDR_W | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_rw_o | output | 1 | Read/write select, high for read |
| dram_dq_i | input | DATA_W | Data from DRAM |
| dram_dq_o | output | DATA_W | Data to DRAM |
| dram_dq_oe_o | output | 1 | Drive enable for dram_dq_o |

## Verification
The address and ready checks assume that the requester keeps req_i, we_i, addr_i and wdata_i steady from the cycle it raises req_i until it sees ready. They also assume it does not present a fresh request in the ready cycle. The refresh strobe-width check assumes T_RAS+1 is at least T_CAS. The stimulus meets these conditions because every access goes through one task: it sets all request inputs together, holds them until ready is seen, and then drops the request. The DRAM model drives read data only while both strobes are low and the select is high.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_COL, ST_CLOSE, ST_PRE, ST_REF_CAS, ST_REF_RAS
  } seq_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int unsigned INTERVAL = 1562
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  localparam int unsigned CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt_q;
  logic          expire;

  assign expire = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CW'(INTERVAL - 1);
      pend_o <= 1'b0;
    end else begin
      cnt_q <= expire ? CW'(INTERVAL - 1) : cnt_q - 1'b1;
      if (expire)     pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_row_tracker.sv
module dram_row_tracker #(
  parameter int unsigned ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic             hit_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      row_q  <= '0;
    end else if (open_i) begin
      open_o <= 1'b1;
      row_q  <= row_i;
    end else if (close_i) begin
      open_o <= 1'b0;
    end
  end

  assign hit_o = open_o && (row_q == row_i);
endmodule

// File: rtl/dram_rd_capture.sv
module dram_rd_capture #(
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (cap_i) rdata_o <= dq_i;
  end
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned DATA_W     = 4,
  parameter int unsigned CLK_KHZ    = 100000,
  parameter int unsigned REF_ROWS   = 512,
  parameter int unsigned REF_WIN_MS = 8,
  parameter int unsigned T_RCD      = 2,
  parameter int unsigned T_CAS      = 2,
  parameter int unsigned T_RAS      = 5,
  parameter int unsigned T_RP       = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [2*ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  ready_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [ADDR_W-1:0]     dram_addr_o,
  output logic                  dram_ras_no,
  output logic                  dram_cas_no,
  output logic                  dram_rw_o,
  input  logic [DATA_W-1:0]     dram_dq_i,
  output logic [DATA_W-1:0]     dram_dq_o,
  output logic                  dram_dq_oe_o
);
  localparam int unsigned REF_INTERVAL = (CLK_KHZ * REF_WIN_MS) / REF_ROWS;
  localparam int unsigned TW  = $clog2(max3(T_RCD, T_CAS, T_RP) + 1);
  localparam int unsigned RCW = $clog2(T_RAS + 1) + 1;

  seq_state_e          state_q;
  logic [TW-1:0]       tcnt_q;
  logic [RCW-1:0]      row_cnt_q;
  logic                ras_n_q, cas_n_q, rw_q, oe_q, ready_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;

  logic [ADDR_W-1:0]   req_row, req_col;
  logic                ref_pend, row_open, row_hit;
  logic                go_ref, go_close, go_act, go_hit;
  logic                col_done, close_now, ref_end, ras_set;

  assign req_row = addr_i[2*ADDR_W-1:ADDR_W];
  assign req_col = addr_i[ADDR_W-1:0];

  dram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ack_i (go_ref),
    .pend_o(ref_pend)
  );

  dram_row_tracker #(.ROW_W(ADDR_W)) u_row (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_i (go_act),
    .close_i(close_now),
    .row_i  (req_row),
    .open_o (row_open),
    .hit_o  (row_hit)
  );

  dram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (col_done && rw_q),
    .dq_i   (dram_dq_i),
    .rdata_o(rdata_o)
  );

  // idle-state arbitration: refresh first, then the waiting request
  always_comb begin
    go_ref   = 1'b0;
    go_close = 1'b0;
    go_act   = 1'b0;
    go_hit   = 1'b0;
    if (state_q == ST_IDLE) begin
      if (ref_pend) begin
        if (row_open) go_close = 1'b1;
        else          go_ref   = 1'b1;
      end else if (req_i && !ready_q) begin
        if (!row_open)    go_act   = 1'b1;
        else if (row_hit) go_hit   = 1'b1;
        else              go_close = 1'b1;
      end
    end
  end

  assign col_done  = (state_q == ST_COL) && (tcnt_q == '0);
  assign close_now = (state_q == ST_CLOSE) && (row_cnt_q >= RCW'(T_RAS));
  assign ref_end   = (state_q == ST_REF_RAS) && (row_cnt_q >= RCW'(T_RAS));
  assign ras_set   = go_act || (state_q == ST_REF_CAS);

  // row strobe age, saturating at T_RAS
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        row_cnt_q <= '0;
    else if (ras_set)                                   row_cnt_q <= RCW'(1);
    else if (!ras_n_q && (row_cnt_q < RCW'(T_RAS)))     row_cnt_q <= row_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
      rw_q    <= 1'b1;
      oe_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (go_ref) begin
            cas_n_q <= 1'b0;
            state_q <= ST_REF_CAS;
          end else if (go_close) begin
            state_q <= ST_CLOSE;
          end else if (go_act) begin
            ras_n_q <= 1'b0;
            addr_q  <= req_row;
            tcnt_q  <= TW'(T_RCD - 1);
            state_q <= ST_ROW;
          end else if (go_hit) begin
            cas_n_q <= 1'b0;
            addr_q  <= req_col;
            rw_q    <= !we_i;
            oe_q    <= we_i;
            wdata_q <= wdata_i;
            tcnt_q  <= TW'(T_CAS - 1);
            state_q <= ST_COL;
          end
        end
        ST_ROW: begin
          if (tcnt_q == '0) begin
            cas_n_q <= 1'b0;
            addr_q  <= req_col;
            rw_q    <= !we_i;
            oe_q    <= we_i;
            wdata_q <= wdata_i;
            tcnt_q  <= TW'(T_CAS - 1);
            state_q <= ST_COL;
          end else begin
            tcnt_q <= tcnt_q - 1'b1;
          end
        end
        ST_COL: begin
          if (tcnt_q == '0) begin
            cas_n_q <= 1'b1;
            oe_q    <= 1'b0;
            rw_q    <= 1'b1;
            ready_q <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            tcnt_q <= tcnt_q - 1'b1;
          end
        end
        ST_CLOSE: begin
          if (close_now) begin
            ras_n_q <= 1'b1;
            tcnt_q  <= TW'(T_RP - 1);
            state_q <= ST_PRE;
          end
        end
        ST_PRE: begin
          if (tcnt_q == '0) state_q <= ST_IDLE;
          else              tcnt_q  <= tcnt_q - 1'b1;
        end
        ST_REF_CAS: begin
          ras_n_q <= 1'b0;
          state_q <= ST_REF_RAS;
        end
        ST_REF_RAS: begin
          if (ref_end) begin
            ras_n_q <= 1'b1;
            cas_n_q <= 1'b1;
            tcnt_q  <= TW'(T_RP - 1);
            state_q <= ST_PRE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o      = ready_q;
  assign dram_addr_o  = addr_q;
  assign dram_ras_no  = ras_n_q;
  assign dram_cas_no  = cas_n_q;
  assign dram_rw_o    = rw_q;
  assign dram_dq_o    = wdata_q;
  assign dram_dq_oe_o = oe_q;
endmodule

// File: rtl/dram_page_ctrl_chk.sv
module dram_page_ctrl_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 4,
  parameter int unsigned T_RCD  = 2,
  parameter int unsigned T_CAS  = 2,
  parameter int unsigned T_RAS  = 5,
  parameter int unsigned T_RP   = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic [2*ADDR_W-1:0] addr_i,
  input logic                ready_o,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [ADDR_W-1:0]   dram_addr_o,
  input logic                dram_ras_no,
  input logic                dram_cas_no,
  input logic                dram_rw_o,
  input logic                dram_dq_oe_o
);
  localparam int unsigned CW = $clog2(T_RCD + T_CAS + T_RAS + T_RP + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] ras_lo_q, ras_hi_q, cas_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_lo_q <= '0;
      ras_hi_q <= CMAX;
      cas_lo_q <= '0;
    end else begin
      ras_lo_q <= dram_ras_no  ? '0 : ((ras_lo_q == CMAX) ? CMAX : ras_lo_q + 1'b1);
      ras_hi_q <= !dram_ras_no ? '0 : ((ras_hi_q == CMAX) ? CMAX : ras_hi_q + 1'b1);
      cas_lo_q <= dram_cas_no  ? '0 : ((cas_lo_q == CMAX) ? CMAX : cas_lo_q + 1'b1);
    end
  end

  // R2
  row_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) && dram_cas_no |-> dram_addr_o == addr_i[2*ADDR_W-1:ADDR_W]);
  // R2
  col_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) && !dram_ras_no |-> dram_addr_o == addr_i[ADDR_W-1:0]);
  // R3
  rcd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) && !dram_ras_no |-> ras_lo_q >= CW'(T_RCD));
  // R4
  cas_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_cas_no) |-> cas_lo_q >= CW'(T_CAS));
  // R5
  wr_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_dq_oe_o |-> !dram_cas_no && !dram_rw_o);
  // R6
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> ready_o);
  // R8
  ras_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_ras_no) |-> ras_lo_q >= CW'(T_RAS));
  // R8
  precharge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> ras_hi_q >= CW'(T_RP));
  // R9
  cas_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) && !dram_cas_no |-> $past(dram_cas_no) == 1'b0);
  // R11
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  // R11
  ready_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(req_i));
endmodule

bind dram_page_ctrl dram_page_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .addr_i      (addr_i),
  .ready_o     (ready_o),
  .rdata_o     (rdata_o),
  .dram_addr_o (dram_addr_o),
  .dram_ras_no (dram_ras_no),
  .dram_cas_no (dram_cas_no),
  .dram_rw_o   (dram_rw_o),
  .dram_dq_oe_o(dram_dq_oe_o)
);

// File: tb/sim_dram_page_ctrl.sv
module sim_dram_page_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4, DW = 8, KHZ = 8000;
  localparam int T_RCD = 2, T_CAS = 2, T_RAS = 4, T_RP = 2;
  localparam int REF_INT = (KHZ * 8) / 512;  // 125 clocks

  // {we, addr, wdata, expected read data}
  localparam logic [24:0] VEC [12] = '{
    {1'b1, 8'h12, 8'hA1, 8'h00},
    {1'b1, 8'h13, 8'hB2, 8'h00},
    {1'b0, 8'h12, 8'h00, 8'hA1},
    {1'b1, 8'h47, 8'hC3, 8'h00},
    {1'b0, 8'h13, 8'h00, 8'hB2},
    {1'b0, 8'h47, 8'h00, 8'hC3},
    {1'b1, 8'h4F, 8'hD4, 8'h00},
    {1'b0, 8'h4F, 8'h00, 8'hD4},
    {1'b0, 8'h20, 8'h00, 8'h7A},
    {1'b1, 8'hF0, 8'h0E, 8'h00},
    {1'b0, 8'hF0, 8'h00, 8'h0E},
    {1'b0, 8'h12, 8'h00, 8'hA1}
  };

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [2*AW-1:0] addr = '0;
  logic [DW-1:0]   wdata = '0;
  logic            ready, ras_n, cas_n, rw, dq_oe;
  logic [DW-1:0]   rdata, dq_in, dq_out;
  logic [AW-1:0]   d_addr;

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  dram_page_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_KHZ(KHZ), .REF_ROWS(512), .REF_WIN_MS(8),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .rdata_o(rdata), .dram_addr_o(d_addr), .dram_ras_no(ras_n),
    .dram_cas_no(cas_n), .dram_rw_o(rw), .dram_dq_i(dq_in), .dram_dq_o(dq_out),
    .dram_dq_oe_o(dq_oe)
  );

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // DRAM model, sampled away from the active edge
  logic [DW-1:0] mem [256];
  logic [DW-1:0] shadow [256];
  logic [AW-1:0] m_row = '0, m_col = '0;
  int  act_cnt = 0, ref_cnt = 0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_rdy = 1'b0;
  int  lo_w = 0, hi_w = 1000, cas_w = 0, gap = 0;
  bit  act_open = 1'b0, cas_acc = 1'b0;

  initial for (int i = 0; i < 256; i++) begin
    mem[i]    = 8'(i) ^ 8'h5A;
    shadow[i] = 8'(i) ^ 8'h5A;
  end

  assign dq_in = (!cas_n && !ras_n && rw) ? mem[{m_row, m_col}] : '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        check(hi_w >= T_RP, "R8 precharge width", hi_w, T_RP);
        if (cas_n) begin
          act_cnt++;
          m_row = d_addr;
          check(d_addr == addr[7:4], "R2 row half", d_addr, addr[7:4]);
          act_open = 1'b1;
          gap = 1;
        end else begin
          ref_cnt++;
          check(!p_cas, "R9 column strobe before row strobe", p_cas, 0);
        end
        lo_w = 1;
      end else if (!ras_n) begin
        lo_w++;
        if (cas_n) gap++;
      end
      if (!p_ras && ras_n) begin
        check(lo_w >= T_RAS, "R8 row strobe width", lo_w, T_RAS);
        hi_w = 1;
      end else if (ras_n) begin
        hi_w++;
      end
      if (p_cas && !cas_n && !ras_n) begin
        if (act_open) check(gap == T_RCD, "R3 row to column delay", gap, T_RCD);
        act_open = 1'b0;
        m_col = d_addr;
        check(d_addr == addr[3:0], "R2 column half", d_addr, addr[3:0]);
        if (!rw) begin
          check(dq_oe && dq_out == wdata, "R5 write data driven", dq_out, wdata);
          mem[{m_row, m_col}] = dq_out;
        end else begin
          check(!dq_oe, "R5 no drive on read", dq_oe, 0);
        end
        cas_acc = 1'b1;
        cas_w = 1;
      end else if (!cas_n) begin
        cas_w++;
        if (cas_acc && !rw) check(dq_oe && dq_out == wdata, "R5 write data held", dq_out, wdata);
      end
      if (!p_cas && cas_n) begin
        if (cas_acc) check(cas_w == T_CAS, "R4 column strobe width", cas_w, T_CAS);
        cas_acc = 1'b0;
      end
      if (ready && p_rdy) check(1'b0, "R11 ready longer than one clock", 2, 1);
    end
    p_ras = ras_n;
    p_cas = cas_n;
    p_rdy = ready;
  end

  // requester model
  logic [AW-1:0] b_row = '0;
  bit  b_valid = 1'b0;
  int  ref_snap = 0;

  task automatic access(input bit w, input logic [7:0] a, input logic [7:0] d, output logic [7:0] rd);
    int t = 0;
    int act0;
    bit exp_act;
    act0 = act_cnt;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    do begin @(negedge clk); t++; end while (!ready && t < 200);
    check(ready, "R11 ready returned", ready, 1);
    rd = rdata;
    req = 1'b0; we = 1'b0;
    exp_act = !b_valid || (a[7:4] != b_row) || (ref_cnt != ref_snap);
    check((act_cnt - act0) == int'(exp_act), "R7 R10 row activations", act_cnt - act0, exp_act);
    if (!exp_act) check(!ras_n, "R7 row kept open", ras_n, 0);
    b_row = a[7:4];
    b_valid = 1'b1;
    ref_snap = ref_cnt;
    if (w) shadow[a] = d;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    repeat (140000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      finish_up();
    end
  end

  initial begin
    logic [7:0] rd;
    int r0, a0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ras_n && cas_n && rw && !dq_oe && !ready, "R1 reset outputs",
          {ras_n, cas_n, rw, dq_oe, ready}, 5'b11100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      access(VEC[i][24], VEC[i][23:16], VEC[i][15:8], rd);
      if (!VEC[i][24]) check(rd == VEC[i][7:0], "R6 read data", rd, VEC[i][7:0]);
    end

    // R9 refresh rate with no traffic
    r0 = ref_cnt;
    repeat (REF_INT * 10) @(negedge clk);
    check((ref_cnt - r0) >= 9 && (ref_cnt - r0) <= 11, "R9 refresh count", ref_cnt - r0, 10);

    // R10 refresh interleaved with same-row traffic
    r0 = ref_cnt;
    a0 = act_cnt;
    for (int i = 0; i < 48; i++) access(1'b1, {4'h6, 4'(i)}, 8'(i * 3 + 1), rd);
    for (int i = 0; i < 48; i++) begin
      access(1'b0, {4'h6, 4'(i)}, 8'h00, rd);
      check(rd == shadow[{4'h6, 4'(i)}], "R6 read after refresh", rd, shadow[{4'h6, 4'(i)}]);
    end
    check((ref_cnt - r0) >= 2, "R9 refresh under load", ref_cnt - r0, 2);
    check((act_cnt - a0) == 1 + (ref_cnt - r0), "R10 reactivation per refresh",
          act_cnt - a0, 1 + (ref_cnt - r0));

    repeat (5) @(negedge clk);
    done = 1'b1;
    finish_up();
  end
endmodule